// File: doc/BRIEF.md
# Ethernet Frame Statistics Counter Bank

This block keeps the per-frame statistics of an Ethernet MAC. At the end of each frame, the transmit path and the receive path each present a one-cycle summary strobe. A receive summary carries the byte length, an FCS error flag, a flag for a frame that does not end on a whole byte, a VLAN-tag flag, a destination class, the EtherType and the control opcode. A transmit summary carries only the length, the FCS error flag and the VLAN flag. The block sorts both directions into one shared frame-length histogram. It also updates a set of receive-only counters for bytes, packets, FCS errors, multicast, broadcast and MAC control traffic.

Every counter is 32 bits wide and saturates rather than wraps. Each counter is reachable through a small register port at a fixed, word-aligned offset. A write loads the counter. A read returns the counter one cycle after the address is presented. The block does no frame parsing, no CRC work and no interrupt signalling; it only counts what it is told.

Top module: `ethstat_bank`

## Requirements
- R1: Length histogram bins cover exactly 64, 65–127, 128–255, 256–511, 512–1023 and 1024–1518 bytes, at offsets 0x80, 0x84, 0x88, 0x8C, 0x90 and 0x94. Each of these bins counts every frame in its range from either path, whatever the error or tag flags.
- R2: The bin at 0x98 counts 1519–1522 byte frames only when they are VLAN-tagged and good. A good frame has no FCS error and, on receive, is not a partial-byte frame. An untagged 1519–1522 frame, and any frame shorter than 64 or longer than 1522 bytes, counts in no bin.
- R3: A transmit strobe and a receive strobe in the same cycle are both counted. One bin can rise by 2, or two bins can each rise by 1.
- R4: The counter at 0x9C adds the length of every received frame. The counter at 0xA0 rises by one per received frame.
- R5: The counter at 0xA4 rises only for a received frame that has an FCS error, is not partial-byte, and has a length of 64 to 1518.
- R6: The counter at 0xA8 counts good received frames with destination code 1 (multicast). The counter at 0xAC counts good received frames with destination code 2 (broadcast). Code 0 is unicast and code 3 counts in neither. Both apply a length limit of 1518 bytes, or 1522 bytes for a tagged frame.
- R7: The counter at 0xB0 counts received frames with EtherType 0x8808. The counter at 0xB4 counts such frames that have opcode 0x0001 and are good. The counter at 0xB8 counts such frames whose opcode is not 0x0001.
- R8: A counter at 0xFFFFFFFF stays there. An add that would pass it leaves 0xFFFFFFFF.
- R9: All counters reset to 0. A write loads the written value and wins over an update in the same cycle. Read data appears one cycle after the address. An unmapped or misaligned address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_vld | input | 1 | Transmit frame-end strobe |
| tx_len | input | 16 | Transmit frame length in bytes |
| tx_fcs_err | input | 1 | Transmit frame had an FCS error |
| tx_vlan | input | 1 | Transmit frame carried a VLAN tag |
| rx_vld | input | 1 | Receive frame-end strobe |
| rx_len | input | 16 | Receive frame length in bytes |
| rx_fcs_err | input | 1 | Receive frame had an FCS error |
| rx_partial | input | 1 | Receive frame did not end on a whole byte |
| rx_vlan | input | 1 | Receive frame carried a VLAN tag |
| rx_dst | input | 2 | Destination class: 0 unicast, 1 multicast, 2 broadcast |
| rx_etype | input | 16 | Receive EtherType |
| rx_opcode | input | 16 | Receive control opcode |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
Saturation is the hardest case to reach from the ports, because counting up to 2^32 frames is out of reach. The stimulus first loads a counter to just below its maximum through the write port. It then sends frames, including a double increment from both paths and a long byte add, that step over the top. The hardest classification case is the interplay of the rules. For that, one long sweep walks transmit lengths upward across every bin edge while receive lengths walk downward in the same cycles. Tag, error, partial, destination and opcode patterns are derived arithmetically from the step number, so every counter sees a mix of qualifying and rejected frames.

// File: rtl/ethstat_pkg.sv
package ethstat_pkg;
  localparam int NUM_BINS = 7;
  localparam int NUM_RX   = 8;
  localparam int NUM_CNT  = NUM_BINS + NUM_RX;

  // receive counter slots, in offset order after the histogram
  localparam int RX_BYTES = 0;
  localparam int RX_PKTS  = 1;
  localparam int RX_FCS   = 2;
  localparam int RX_MC    = 3;
  localparam int RX_BC    = 4;
  localparam int RX_CTRL  = 5;
  localparam int RX_PAUSE = 6;
  localparam int RX_UNK   = 7;

  typedef enum logic [1:0] {
    DST_UNI   = 2'd0,
    DST_MULTI = 2'd1,
    DST_BCAST = 2'd2,
    DST_NONE  = 2'd3
  } dst_e;

  localparam logic [15:0] ETYPE_CTRL = 16'h8808;
  localparam logic [15:0] OP_PAUSE   = 16'h0001;
endpackage

// File: rtl/ethstat_bin_sel.sv
module ethstat_bin_sel #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] len,
  input  logic             vlan,
  input  logic             bad,
  output logic [ethstat_pkg::NUM_BINS-1:0] bin
);
  always_comb begin
    bin = '0;
    if (len == LEN_W'(64))                               bin[0] = 1'b1;
    else if (len >= LEN_W'(65)   && len <= LEN_W'(127))  bin[1] = 1'b1;
    else if (len >= LEN_W'(128)  && len <= LEN_W'(255))  bin[2] = 1'b1;
    else if (len >= LEN_W'(256)  && len <= LEN_W'(511))  bin[3] = 1'b1;
    else if (len >= LEN_W'(512)  && len <= LEN_W'(1023)) bin[4] = 1'b1;
    else if (len >= LEN_W'(1024) && len <= LEN_W'(1518)) bin[5] = 1'b1;
    else if (len >= LEN_W'(1519) && len <= LEN_W'(1522) && vlan && !bad)
                                                         bin[6] = 1'b1;
  end

  // R1
  bin_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(bin));
  // R2
  long_untagged_chk: assert property (@(posedge clk) disable iff (rst)
    (len > LEN_W'(1518) && !vlan) |-> (bin == '0));
endmodule

// File: rtl/ethstat_rx_rules.sv
module ethstat_rx_rules #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic [LEN_W-1:0] len,
  input  logic             fcs_err,
  input  logic             partial,
  input  logic             vlan,
  input  logic [1:0]       dst,
  input  logic [15:0]      etype,
  input  logic [15:0]      opcode,
  output logic [ethstat_pkg::NUM_RX-1:0] hit
);
  import ethstat_pkg::*;

  logic good, len_ok, is_ctrl;
  dst_e dcls;

  always_comb begin
    dcls    = dst_e'(dst);
    good    = !fcs_err && !partial;
    len_ok  = len <= (vlan ? LEN_W'(1522) : LEN_W'(1518));
    is_ctrl = etype == ETYPE_CTRL;
    hit = '0;
    hit[RX_BYTES] = vld;
    hit[RX_PKTS]  = vld;
    hit[RX_FCS]   = vld && fcs_err && !partial &&
                    len >= LEN_W'(64) && len <= LEN_W'(1518);
    hit[RX_MC]    = vld && good && len_ok && dcls == DST_MULTI;
    hit[RX_BC]    = vld && good && len_ok && dcls == DST_BCAST;
    hit[RX_CTRL]  = vld && is_ctrl;
    hit[RX_PAUSE] = vld && is_ctrl && good && opcode == OP_PAUSE;
    hit[RX_UNK]   = vld && is_ctrl && opcode != OP_PAUSE;
  end

  // R6
  mc_bc_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(hit[RX_MC] && hit[RX_BC]));
  // R7
  pause_is_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    (hit[RX_PAUSE] || hit[RX_UNK]) |-> hit[RX_CTRL]);
  // R7
  pause_unk_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(hit[RX_PAUSE] && hit[RX_UNK]));
endmodule

// File: rtl/ethstat_sat_cnt.sv
module ethstat_sat_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] inc,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W:0] sum;

  always_comb sum = {1'b0, cnt} + {1'b0, inc};

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (wr)             cnt <= wdata;
    else if (sum[CNT_W])     cnt <= '1;
    else                     cnt <= sum[CNT_W-1:0];
  end

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !wr |=> cnt >= $past(cnt));
  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr && cnt == '1) |=> cnt == '1);
  // R9
  wr_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> cnt == $past(wdata));
endmodule

// File: rtl/ethstat_bank.sv
module ethstat_bank #(
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_vld,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic              tx_fcs_err,
  input  logic              tx_vlan,
  input  logic              rx_vld,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic              rx_fcs_err,
  input  logic              rx_partial,
  input  logic              rx_vlan,
  input  logic [1:0]        rx_dst,
  input  logic [15:0]       rx_etype,
  input  logic [15:0]       rx_opcode,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata
);
  import ethstat_pkg::*;

  localparam int IDX_W = $clog2(NUM_CNT);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * NUM_CNT);

  logic [NUM_BINS-1:0] tx_bin, rx_bin;
  logic [NUM_RX-1:0]   rx_hit;
  logic [CNT_W-1:0]    inc  [NUM_CNT];
  logic [CNT_W-1:0]    cnt  [NUM_CNT];
  logic [ADDR_W-1:0]   rel;
  logic                map_hit;
  logic [IDX_W-1:0]    idx;

  ethstat_bin_sel #(.LEN_W(LEN_W)) u_tx_bin (
    .clk(clk), .rst(rst), .len(tx_len), .vlan(tx_vlan),
    .bad(tx_fcs_err), .bin(tx_bin));

  ethstat_bin_sel #(.LEN_W(LEN_W)) u_rx_bin (
    .clk(clk), .rst(rst), .len(rx_len), .vlan(rx_vlan),
    .bad(rx_fcs_err || rx_partial), .bin(rx_bin));

  ethstat_rx_rules #(.LEN_W(LEN_W)) u_rules (
    .clk(clk), .rst(rst), .vld(rx_vld), .len(rx_len),
    .fcs_err(rx_fcs_err), .partial(rx_partial), .vlan(rx_vlan),
    .dst(rx_dst), .etype(rx_etype), .opcode(rx_opcode), .hit(rx_hit));

  always_comb begin
    rel     = reg_addr - BASE;
    map_hit = (reg_addr >= BASE) && (rel < SPAN) && (reg_addr[1:0] == 2'b00);
    idx     = IDX_W'(rel >> 2);
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    if (i < NUM_BINS) begin : g_hist
      always_comb inc[i] = {{(CNT_W-1){1'b0}}, tx_vld && tx_bin[i]}
                         + {{(CNT_W-1){1'b0}}, rx_vld && rx_bin[i]};
    end else if (i == NUM_BINS + RX_BYTES) begin : g_bytes
      always_comb inc[i] = rx_hit[RX_BYTES] ? {{(CNT_W-LEN_W){1'b0}}, rx_len} : '0;
    end else begin : g_flag
      always_comb inc[i] = {{(CNT_W-1){1'b0}}, rx_hit[i-NUM_BINS]};
    end

    ethstat_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst),
      .wr(reg_wr && map_hit && idx == IDX_W'(i)),
      .wdata(reg_wdata), .inc(inc[i]), .cnt(cnt[i]));
  end

  always_ff @(posedge clk) begin
    if (rst)          reg_rdata <= '0;
    else if (map_hit) reg_rdata <= cnt[idx];
    else              reg_rdata <= '0;
  end

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !map_hit |=> reg_rdata == '0);
  // R3
  dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_vld && rx_vld && tx_len == rx_len && tx_len == LEN_W'(300) && !reg_wr
     && cnt[3] < 32'hFFFF_0000) |=> cnt[3] == $past(cnt[3]) + 2);
endmodule

// File: tb/ethstat_bank_test.sv
module ethstat_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_vld = 0, tx_fcs_err = 0, tx_vlan = 0;
  logic [15:0] tx_len = 0;
  logic        rx_vld = 0, rx_fcs_err = 0, rx_partial = 0, rx_vlan = 0;
  logic [15:0] rx_len = 0, rx_etype = 0, rx_opcode = 0;
  logic [1:0]  rx_dst = 0;
  logic        reg_wr = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;

  int n_chk = 0, n_bad = 0;
  longint exp_c [15];

  always #2 clk = ~clk;

  ethstat_bank uut (.*);

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  function automatic int bin_of(int len, bit vlan, bit bad);
    if (len == 64) return 0;
    if (len >= 65 && len <= 127) return 1;
    if (len >= 128 && len <= 255) return 2;
    if (len >= 256 && len <= 511) return 3;
    if (len >= 512 && len <= 1023) return 4;
    if (len >= 1024 && len <= 1518) return 5;
    if (len >= 1519 && len <= 1522 && vlan && !bad) return 6;
    return 7;
  endfunction

  function automatic void bump(int k, longint v);
    exp_c[k] = exp_c[k] + v;
    if (exp_c[k] > 64'hFFFF_FFFF) exp_c[k] = 64'hFFFF_FFFF;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    for (int k = 0; k < 15; k++) exp_c[k] = 0;
  endtask

  task automatic check_all(string req);
    logic [31:0] d;
    for (int k = 0; k < 15; k++) begin
      rd(8'h80 + 8'(4 * k), d);
      check($sformatf("%s ctr@%h", req, 8'h80 + 8'(4 * k)), d, exp_c[k][31:0]);
    end
  endtask

  // transmit and receive strobes for one cycle, model updated from requirements
  task automatic frame(bit tv, int tl, bit tf, bit tg,
                       bit rv, int rl, bit rf, bit rp, bit rg,
                       int rd_, int et, int op);
    int b;
    bit good;
    @(negedge clk);
    tx_vld = tv; tx_len = 16'(tl); tx_fcs_err = tf; tx_vlan = tg;
    rx_vld = rv; rx_len = 16'(rl); rx_fcs_err = rf; rx_partial = rp;
    rx_vlan = rg; rx_dst = 2'(rd_); rx_etype = 16'(et); rx_opcode = 16'(op);
    if (tv) begin b = bin_of(tl, tg, tf); if (b < 7) bump(b, 1); end   // R1 R2 R3
    if (rv) begin
      good = !rf && !rp;
      b = bin_of(rl, rg, !good); if (b < 7) bump(b, 1);
      bump(7, rl); bump(8, 1);                                          // R4
      if (rf && !rp && rl >= 64 && rl <= 1518) bump(9, 1);             // R5
      if (good && rl <= (rg ? 1522 : 1518)) begin                       // R6
        if (rd_ == 1) bump(10, 1);
        if (rd_ == 2) bump(11, 1);
      end
      if (et == 16'h8808) begin                                         // R7
        bump(12, 1);
        if (op == 1 && good) bump(13, 1);
        if (op != 1) bump(14, 1);
      end
    end
    @(negedge clk); tx_vld = 0; rx_vld = 0;
  endtask

  initial begin
    logic [31:0] d;
    do_reset();
    check_all("R9 reset");

    // R3: both paths same bin, then different bins
    frame(1, 300, 0, 0, 1, 300, 0, 0, 0, 0, 16'h0800, 0);
    frame(1, 64, 1, 0, 1, 1522, 0, 0, 1, 1, 16'h0800, 0);
    check_all("R3 dual strobe");

    // R2: rejected lengths
    frame(1, 1520, 0, 0, 1, 63, 0, 0, 1, 0, 16'h0800, 0);
    frame(1, 1523, 0, 1, 1, 1521, 1, 0, 1, 0, 16'h0800, 0);
    check_all("R2 rejects");

    // R9: write wins over same-cycle update
    @(negedge clk);
    reg_wr = 1; reg_addr = 8'h80; reg_wdata = 32'd100; tx_vld = 1; tx_len = 64;
    tx_fcs_err = 0; tx_vlan = 0;
    @(negedge clk); reg_wr = 0; tx_vld = 0;
    exp_c[0] = 100;
    rd(8'h80, d); check("R9 write priority", d, 32'd100);
    rd(8'h82, d); check("R9 misaligned", d, 32'd0);
    rd(8'hBC, d); check("R9 unmapped high", d, 32'd0);
    rd(8'h7C, d); check("R9 unmapped low", d, 32'd0);

    // R8: saturation via double increment and byte add
    wr(8'h80, 32'hFFFF_FFFE); exp_c[0] = 64'hFFFF_FFFE;
    wr(8'h9C, 32'hFFFF_FFF0); exp_c[7] = 64'hFFFF_FFF0;
    frame(1, 64, 0, 0, 1, 64, 0, 0, 0, 0, 16'h0800, 0);
    rd(8'h80, d); check("R8 hist sat", d, 32'hFFFF_FFFF);
    rd(8'h9C, d); check("R8 byte sat", d, 32'hFFFF_FFFF);
    frame(1, 64, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    rd(8'h80, d); check("R8 sat hold", d, 32'hFFFF_FFFF);

    // sweep: R1 R2 R4 R5 R6 R7 across every length edge
    do_reset();
    for (int i = 0; i <= 1530; i++) begin
      frame(1, i, (i % 7) == 3, (i % 2) == 1,
            1, 1530 - i, (i % 11) == 5, (i % 13) == 6, (i % 3) == 1,
            i % 4, ((i % 5) == 0) ? 16'h8808 : 16'h0800,
            ((i % 10) == 0 || (i % 3) == 0) ? 1 : i);
    end
    check_all("R1 R4 R5 R6 R7 sweep");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule